// File: doc/BRIEF.md
# Exponential Control-to-Delay Mapper

This block converts a 10-bit control code, typically a potentiometer reading, into a delay length expressed as a count of timer ticks. The mapping follows a roughly exponential curve, so small codes give fine control over short delays and large codes reach long delays, but it is built only from shifts, one multiply and an add. The three most significant bits of the code choose a segment whose starting tick count is a base of 36 ticks doubled once per segment step. The seven least significant bits then move linearly across that segment toward the start of the next one.

A code is presented with a one-cycle valid strobe. The tick count leaves the block with its own valid strobe exactly two clock cycles later. A new code may be presented on every cycle, and results come out in the same order. Between results the output count holds its last value.

Top module: `exp_delay_map`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_ticks is 0.
- R2: Every result lies between 36 and 9180 inclusive.
- R3: For code c, with segment s = c[9:7] and fraction f = c[6:0], the result is S + ((S × f) >> 7) where S = 36 << s. Intermediate values are computed without overflow, and the result is truncated to 16 bits.
- R4: Code 0 gives exactly 36 ticks. Code 1023 gives exactly 9180 ticks.
- R5: A code whose fraction bits c[6:0] are all zero gives exactly 36 << c[9:7], that is 36, 72, 144, 288, 576, 1152, 2304 or 4608.
- R6: out_valid is high in the cycle two clock edges after a cycle with in_valid high, and low two edges after a cycle with in_valid low.
- R7: Codes presented on consecutive cycles each produce their own result on consecutive cycles, in the order they were given.
- R8: The result never decreases as the code increases from 0 to 1023.
- R9: While out_valid is low, out_ticks keeps the value of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_code as a new request this cycle |
| in_code | input | 10 | Control code: bits 9:7 select the segment, bits 6:0 the fraction |
| out_valid | output | 1 | Marks out_ticks as a fresh result |
| out_ticks | output | 16 | Delay length in timer ticks |

## Verification
The bench sweeps every code from 0 to 1023 back to back. A design that drops or reorders pipelined results, or that breaks the monotonic curve at a segment boundary, shows up as a mismatch or a decrease there. The extreme codes 0 and 1023 and the eight segment starts are checked against exact values. A multiply done too narrow would wrap the top segment, and a wrong shift or an off-by-one segment select would miss by a factor of two. Random codes with gaps in the valid strobe test the two-cycle latency and the hold of the output between results, which a design that updates the count on idle cycles would fail.

// File: rtl/exp_delay_pkg.sv
package exp_delay_pkg;

    // Default geometry of the mapper.
    localparam int CODE_W     = 10;
    localparam int SEG_SEL_W  = 3;
    localparam int FRAC_W     = CODE_W - SEG_SEL_W;
    localparam int BASE_TICKS = 36;
    localparam int TICK_W     = 16;

    // Width needed to hold the largest segment start value.
    function automatic int seg_width(input int base, input int sel_w);
        return $clog2(base + 1) + (2 ** sel_w) - 1;
    endfunction

    // Largest result the mapper can produce (top code).
    function automatic longint max_result(input int base, input int sel_w, input int frac_w);
        longint top_seg;
        longint top_frac;
        top_seg  = longint'(base) << ((2 ** sel_w) - 1);
        top_frac = (longint'(1) << frac_w) - 1;
        return top_seg + ((top_seg * top_frac) >> frac_w);
    endfunction

endpackage

// File: rtl/exp_delay_seg.sv
module exp_delay_seg
    import exp_delay_pkg::*;
#(
    parameter int SEL_W = SEG_SEL_W,
    parameter int FRW   = FRAC_W,
    parameter int BASE  = BASE_TICKS,
    localparam int IN_W  = SEL_W + FRW,
    localparam int SEG_W = seg_width(BASE, SEL_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             code_v,
    input  logic [IN_W-1:0]  code,
    output logic             seg_v,
    output logic [SEG_W-1:0] seg_start,
    output logic [FRW-1:0]   seg_frac
);

    logic [SEL_W-1:0] sel;
    logic [SEG_W-1:0] start_next;

    always_comb begin
        sel        = code[IN_W-1:FRW];
        start_next = SEG_W'(BASE) << sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_v     <= 1'b0;
            seg_start <= '0;
            seg_frac  <= '0;
        end else begin
            seg_v <= code_v;
            if (code_v) begin
                seg_start <= start_next;
                seg_frac  <= code[FRW-1:0];
            end
        end
    end

    // R6: a request moves into this stage on the next edge.
    a_r6_seg_follow: assert property (@(posedge clk) disable iff (rst)
        code_v |=> seg_v);
    // R6: no request, no stage-one valid.
    a_r6_seg_idle: assert property (@(posedge clk) disable iff (rst)
        !code_v |=> !seg_v);
    // R5: a segment start is the base scaled by a power of two, so its bit count is that of the base.
    a_r5_seg_power: assert property (@(posedge clk) disable iff (rst)
        seg_v |-> ($countones(seg_start) == $countones(SEG_W'(BASE))));

endmodule

// File: rtl/exp_delay_interp.sv
module exp_delay_interp
    import exp_delay_pkg::*;
#(
    parameter int SEL_W = SEG_SEL_W,
    parameter int FRW   = FRAC_W,
    parameter int BASE  = BASE_TICKS,
    parameter int OUT_W = TICK_W,
    localparam int SEG_W  = seg_width(BASE, SEL_W),
    localparam int PROD_W = SEG_W + FRW,
    localparam int FULL_W = (PROD_W + 1 > OUT_W) ? PROD_W + 1 : OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_v,
    input  logic [SEG_W-1:0] seg_start,
    input  logic [FRW-1:0]   seg_frac,
    output logic             res_v,
    output logic [OUT_W-1:0] res_ticks
);

    localparam longint MAX_RES = max_result(BASE, SEL_W, FRW);

    logic [PROD_W-1:0] prod;
    logic [FULL_W-1:0] sum_full;

    always_comb begin
        prod     = PROD_W'(seg_start) * PROD_W'(seg_frac);
        sum_full = FULL_W'(seg_start) + FULL_W'(prod >> FRW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_v     <= 1'b0;
            res_ticks <= '0;
        end else begin
            res_v <= seg_v;
            if (seg_v) begin
                res_ticks <= sum_full[OUT_W-1:0];
            end
        end
    end

    // R9: the count only moves when a result is written.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !seg_v |=> $stable(res_ticks));
    // R2: every result stays inside the curve's range.
    a_r2_result_range: assert property (@(posedge clk) disable iff (rst)
        res_v |-> (longint'(res_ticks) >= longint'(BASE) && longint'(res_ticks) <= MAX_RES));
    // R6: stage two follows stage one by one edge.
    a_r6_res_follow: assert property (@(posedge clk) disable iff (rst)
        seg_v |=> res_v);

endmodule

// File: rtl/exp_delay_map.sv
module exp_delay_map
    import exp_delay_pkg::*;
#(
    parameter int SEL_W = SEG_SEL_W,
    parameter int FRW   = FRAC_W,
    parameter int BASE  = BASE_TICKS,
    parameter int OUT_W = TICK_W,
    localparam int IN_W  = SEL_W + FRW,
    localparam int SEG_W = seg_width(BASE, SEL_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_code,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_ticks
);

    logic             mid_v;
    logic [SEG_W-1:0] mid_start;
    logic [FRW-1:0]   mid_frac;

    exp_delay_seg #(
        .SEL_W (SEL_W),
        .FRW   (FRW),
        .BASE  (BASE)
    ) seg_i (
        .clk       (clk),
        .rst       (rst),
        .code_v    (in_valid),
        .code      (in_code),
        .seg_v     (mid_v),
        .seg_start (mid_start),
        .seg_frac  (mid_frac)
    );

    exp_delay_interp #(
        .SEL_W (SEL_W),
        .FRW   (FRW),
        .BASE  (BASE),
        .OUT_W (OUT_W)
    ) interp_i (
        .clk       (clk),
        .rst       (rst),
        .seg_v     (mid_v),
        .seg_start (mid_start),
        .seg_frac  (mid_frac),
        .res_v     (out_valid),
        .res_ticks (out_ticks)
    );

    // R1: reset clears the result interface on the following edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_ticks == '0));

endmodule

// File: tb/exp_delay_map_tb.sv
module exp_delay_map_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [9:0]  in_code = '0;
    logic        out_valid;
    logic [15:0] out_ticks;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Two-slot model of what was driven two and one cycles ago.
    bit          p1_v = 1'b0, p2_v = 1'b0;
    int          p1_c = 0,   p2_c = 0;
    logic [15:0] held = '0;
    bit          sweep_on = 1'b0;
    int          sweep_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_delay_map dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .out_valid (out_valid),
        .out_ticks (out_ticks)
    );

    function automatic int ref_ticks(input int code);
        longint s;
        longint f;
        longint r;
        s = longint'(36) << ((code >> 7) & 7);
        f = code & 127;
        r = s + ((s * f) >> 7);
        return int'(r & 16'hFFFF);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic observe();
        int e;
        string tag;
        if (p2_v) begin
            e = ref_ticks(p2_c);
            if (p2_c == 0 || p2_c == 1023) tag = "R4 extreme code";
            else if ((p2_c & 127) == 0)    tag = "R5 segment start";
            else if (sweep_on)             tag = "R7 back-to-back result";
            else                           tag = "R3 interpolated value";
            check(out_valid == 1'b1, "R6 out_valid after request", int'(out_valid), 1);
            check(int'(out_ticks) == e, tag, int'(out_ticks), e);
            check(out_ticks >= 16'd36 && out_ticks <= 16'd9180, "R2 range", int'(out_ticks), e);
            if (sweep_on) begin
                check(int'(out_ticks) >= sweep_prev, "R8 monotonic", int'(out_ticks), sweep_prev);
                sweep_prev = int'(out_ticks);
            end
            held = out_ticks;
        end else begin
            check(out_valid == 1'b0, "R6 out_valid idle", int'(out_valid), 0);
            check(out_ticks == held, "R9 hold while idle", int'(out_ticks), int'(held));
        end
    endtask

    task automatic step(input bit v, input int code);
        @(negedge clk);
        observe();
        p2_v = p1_v; p2_c = p1_c;
        p1_v = v;    p1_c = code;
        in_valid = v;
        in_code  = 10'(code);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        int dummy;
        dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held.
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_ticks == 16'd0, "R1 reset ticks", int'(out_ticks), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset valid", int'(out_valid), 0);
        check(out_ticks == 16'd0, "R1 after reset ticks", int'(out_ticks), 0);

        // R4 and R5: directed extremes and segment starts, spaced by idle cycles.
        step(1, 0);    step(0, 0); step(0, 0);
        step(1, 1023); step(0, 0); step(0, 0);
        for (int k = 0; k < 8; k++) begin
            step(1, k * 128);
            step(0, 0);
        end
        for (int k = 0; k < 8; k++) step(1, k * 128 + 127);
        step(0, 0); step(0, 0);
        check(held == 16'd9180, "R4 top of curve held", int'(held), 9180);

        // R7 and R8: full sweep, one code per cycle.
        sweep_on = 1'b1;
        sweep_prev = 0;
        for (int c = 0; c < 1024; c++) step(1, c);
        step(0, 0); step(0, 0);
        sweep_on = 1'b0;

        // R3, R6, R9: random codes with random gaps in the strobe.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, int'($urandom % 1024));
        end
        step(0, 0); step(0, 0); step(0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule